// File: doc/BRIEF.md
# Register-Target Branch Condition Unit

This block decides conditional branches and conditional moves for a processor pipeline in which the jump target is always read from a register that the pipeline fetched ahead of time. Nothing adds an offset to the instruction pointer to form the target. One selected test is applied to a condition register value: its sign bit, its lowest bit, or whether the value is zero. An optional inversion can be applied to the result. The outcome drives either a branch or a move-enable.

For each valid request the block returns a registered result one cycle later. The result is the branch decision or move enable, the next instruction pointer, and a link write that stores the current instruction pointer for a taken branch. The condition register index 0 always reads as zero. Combined with the zero test, it gives an unconditional jump or move. One condition code is held back for a future not-a-number test. It decodes as never true and raises an illegal-condition flag.

Top module: `brc_unit`

## Requirements
- R1: Results are registered. `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid`=1, and 0 otherwise. After reset, all outputs are 0.
- R2: `cond_sel`=2'b00 tests for zero. It is true when the condition value is all zeros. When `cond_idx`=0, the condition value is taken as zero, whatever `cond_val` carries.
- R3: `cond_sel`=2'b01 is true when the most significant bit of the condition value is 1.
- R4: `cond_sel`=2'b10 is true when the least significant bit (bit 0) of the condition value is 1.
- R5: `cond_neg`=1 inverts the result of codes 2'b00, 2'b01 and 2'b10. This gives the nonzero, MSB-clear and LSB-clear tests.
- R6: `cond_sel`=2'b11 is reserved. It is never true, even when `cond_neg`=1, and it sets `illegal_cond`=1 for that result.
- R7: A taken branch (`is_move`=0, condition true) gives `taken`=1. It also gives `next_ip` equal to `target_val` with bits [1:0] forced to 0.
- R8: When no branch is taken, `next_ip` is `cur_ip`+4, modulo 2^W.
- R9: A taken branch with `link_idx`≠0 gives `link_we`=1, `link_data`=`cur_ip` and `link_idx_out`=`link_idx`. If `link_idx`=0, `link_we` stays 0.
- R10: A conditional move (`is_move`=1) gives `move_en` equal to the condition. It also gives `taken`=0 and `link_we`=0, and `next_ip` follows R8.
- R11: While `out_valid`=0, the outputs `taken`, `move_en`, `link_we` and `illegal_cond` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| is_move | input | 1 | 1 = conditional move, 0 = branch |
| cond_idx | input | IDXW | Index of the condition register (0 reads as zero) |
| cond_val | input | W | Value of the condition register |
| cond_sel | input | 2 | Test select: 00 zero, 01 MSB, 10 LSB, 11 reserved |
| cond_neg | input | 1 | Invert the selected test |
| target_val | input | W | Prefetched target register value |
| cur_ip | input | W | Current instruction pointer |
| link_idx | input | IDXW | Link register index (0 suppresses the write) |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| move_en | output | 1 | Conditional move enable |
| illegal_cond | output | 1 | Reserved condition code was used |
| next_ip | output | W | Next instruction pointer |
| link_we | output | 1 | Link register write enable |
| link_idx_out | output | IDXW | Link register index for the write |
| link_data | output | W | Value to write into the link register |

## Verification
Every result comes from one register stage. The outputs change at the first rising edge after a request is presented and hold their values until the next edge. The bench drives each request on a falling edge and releases the strobe on the next falling edge. It compares every output in the half cycle after the sampling edge. After the strobe is released, one more falling edge is used to confirm that `out_valid` and the decision outputs have returned to 0. The expected values come from the bench's own model of the tests.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    CS_ZERO = 2'b00,
    CS_MSB  = 2'b01,
    CS_LSB  = 2'b10,
    CS_RSVD = 2'b11
  } cond_sel_e;

  typedef struct packed {
    logic hit;
    logic illegal;
  } cond_res_t;

  // Evaluate one condition test on a full-width value.
  function automatic cond_res_t eval_cond(input logic [63:0] val, input int unsigned w,
                                          input cond_sel_e sel, input logic neg);
    cond_res_t r;
    logic raw;
    r.illegal = 1'b0;
    unique case (sel)
      CS_ZERO: raw = (val == '0);
      CS_MSB:  raw = val[w-1];
      CS_LSB:  raw = val[0];
      default: raw = 1'b0;
    endcase
    if (sel == CS_RSVD) begin
      r.hit     = 1'b0;
      r.illegal = 1'b1;
    end else begin
      r.hit = raw ^ neg;
    end
    return r;
  endfunction

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval #(
  parameter int W    = 64,
  parameter int IDXW = 6
) (
  input  logic [IDXW-1:0] cond_idx,
  input  logic [W-1:0]    cond_val,
  input  logic [1:0]      cond_sel,
  input  logic            cond_neg,
  output logic            hit,
  output logic            illegal
);
  import brc_pkg::*;

  logic [W-1:0]  eff_val;
  logic [63:0]   wide_val;
  cond_res_t     res;

  // Register index 0 reads as zero.
  assign eff_val  = (cond_idx == '0) ? '0 : cond_val;
  assign wide_val = 64'(eff_val);

  always_comb begin
    res     = eval_cond(wide_val, W, cond_sel_e'(cond_sel), cond_neg);
    hit     = res.hit;
    illegal = res.illegal;
  end

  // R6: reserved code is never a hit
  always_comb begin
    a_r6_rsvd_never_hit : assert (!(cond_sel == 2'b11 && hit));
  end
endmodule

// File: rtl/brc_ip_select.sv
module brc_ip_select #(
  parameter int W = 64
) (
  input  logic         do_jump,
  input  logic [W-1:0] target_val,
  input  logic [W-1:0] cur_ip,
  output logic [W-1:0] next_ip
);
  localparam logic [W-1:0] STEP  = W'(4);
  localparam logic [W-1:0] AMASK = ~W'(3);

  logic [W-1:0] seq_ip;
  logic [W-1:0] jmp_ip;

  assign seq_ip  = cur_ip + STEP;
  assign jmp_ip  = target_val & AMASK;
  assign next_ip = do_jump ? jmp_ip : seq_ip;
endmodule

// File: rtl/brc_link_ctl.sv
module brc_link_ctl #(
  parameter int IDXW = 6
) (
  input  logic            do_jump,
  input  logic [IDXW-1:0] link_idx,
  output logic            link_we
);
  assign link_we = do_jump && (link_idx != '0);
endmodule

// File: rtl/brc_unit.sv
module brc_unit #(
  parameter int W    = 64,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            is_move,
  input  logic [IDXW-1:0] cond_idx,
  input  logic [W-1:0]    cond_val,
  input  logic [1:0]      cond_sel,
  input  logic            cond_neg,
  input  logic [W-1:0]    target_val,
  input  logic [W-1:0]    cur_ip,
  input  logic [IDXW-1:0] link_idx,
  output logic            out_valid,
  output logic            taken,
  output logic            move_en,
  output logic            illegal_cond,
  output logic [W-1:0]    next_ip,
  output logic            link_we,
  output logic [IDXW-1:0] link_idx_out,
  output logic [W-1:0]    link_data
);
  // Named internal events.
  logic         cond_hit;
  logic         cond_bad;
  logic         jump_now;
  logic         move_now;
  logic         lwe_now;
  logic [W-1:0] nip_now;

  brc_cond_eval #(.W(W), .IDXW(IDXW)) u_cond (
    .cond_idx (cond_idx),
    .cond_val (cond_val),
    .cond_sel (cond_sel),
    .cond_neg (cond_neg),
    .hit      (cond_hit),
    .illegal  (cond_bad)
  );

  assign jump_now = in_valid && !is_move && cond_hit;
  assign move_now = in_valid && is_move && cond_hit;

  brc_ip_select #(.W(W)) u_ip (
    .do_jump    (jump_now),
    .target_val (target_val),
    .cur_ip     (cur_ip),
    .next_ip    (nip_now)
  );

  brc_link_ctl #(.IDXW(IDXW)) u_link (
    .do_jump  (jump_now),
    .link_idx (link_idx),
    .link_we  (lwe_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      taken        <= 1'b0;
      move_en      <= 1'b0;
      illegal_cond <= 1'b0;
      next_ip      <= '0;
      link_we      <= 1'b0;
      link_idx_out <= '0;
      link_data    <= '0;
    end else begin
      out_valid    <= in_valid;
      taken        <= jump_now;
      move_en      <= move_now;
      illegal_cond <= in_valid && cond_bad;
      link_we      <= lwe_now;
      if (in_valid) begin
        next_ip      <= nip_now;
        link_idx_out <= link_idx;
        link_data    <= cur_ip;
      end
    end
  end

  // R1: a request yields a valid result one cycle later
  a_r1_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6: reserved code flags illegal and never decides
  a_r6_rsvd_flagged : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 2'b11) |=> (illegal_cond && !taken && !move_en));
  // R7: a taken target is word aligned
  a_r7_target_aligned : assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (next_ip[1:0] == 2'b00));
  // R8: not-taken result steps the pointer by 4
  a_r8_seq_step : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !jump_now) |=> (next_ip == $past(cur_ip) + W'(4)));
  // R9: link writes only on taken branches with a nonzero index
  a_r9_link_only_taken : assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (taken && link_idx_out != '0));
  // R10: a move never takes a branch
  a_r10_move_excl : assert property (@(posedge clk) disable iff (!rst_n)
    !(move_en && taken));
  // R11: idle cycles carry no decision
  a_r11_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(taken || move_en || link_we || illegal_cond));
endmodule

// File: tb/brc_unit_bench.sv
module brc_unit_bench;
  localparam int W = 64;
  localparam int IDXW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            is_move = 1'b0;
  logic [IDXW-1:0] cond_idx = '0;
  logic [W-1:0]    cond_val = '0;
  logic [1:0]      cond_sel = '0;
  logic            cond_neg = 1'b0;
  logic [W-1:0]    target_val = '0;
  logic [W-1:0]    cur_ip = '0;
  logic [IDXW-1:0] link_idx = '0;
  logic            out_valid, taken, move_en, illegal_cond, link_we;
  logic [W-1:0]    next_ip, link_data;
  logic [IDXW-1:0] link_idx_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  brc_unit #(.W(W), .IDXW(IDXW)) u_brc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_move(is_move),
    .cond_idx(cond_idx), .cond_val(cond_val), .cond_sel(cond_sel),
    .cond_neg(cond_neg), .target_val(target_val), .cur_ip(cur_ip),
    .link_idx(link_idx), .out_valid(out_valid), .taken(taken),
    .move_en(move_en), .illegal_cond(illegal_cond), .next_ip(next_ip),
    .link_we(link_we), .link_idx_out(link_idx_out), .link_data(link_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model of the condition tests.
  function automatic logic model_hit(input logic [IDXW-1:0] idx, input logic [W-1:0] v,
                                     input logic [1:0] s, input logic n);
    logic [W-1:0] x;
    x = (idx == 0) ? '0 : v;
    if (s == 2'd3) return 1'b0;
    if (s == 2'd0) return n ? (x != 0) : (x == 0);
    if (s == 2'd1) return n ? ~x[W-1] : x[W-1];
    return n ? ~x[0] : x[0];
  endfunction

  // Issue one request and check every output after the sampling edge.
  task automatic run(input string req, input logic mv, input logic [IDXW-1:0] ci,
                     input logic [W-1:0] cv, input logic [1:0] cs, input logic cn,
                     input logic [W-1:0] tv, input logic [W-1:0] ip,
                     input logic [IDXW-1:0] li);
    logic h, jt;
    logic [W-1:0] exp_ip;
    h  = model_hit(ci, cv, cs, cn);
    jt = h && !mv;
    exp_ip = jt ? {tv[W-1:2], 2'b00} : ip + 64'd4;
    @(negedge clk);
    in_valid = 1'b1; is_move = mv; cond_idx = ci; cond_val = cv; cond_sel = cs;
    cond_neg = cn; target_val = tv; cur_ip = ip; link_idx = li;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R1 out_valid"}, W'(out_valid), 1);
    chk({req, " taken"}, W'(taken), W'(jt));
    chk({req, " move_en"}, W'(move_en), W'(h && mv));
    chk({req, " R6 illegal"}, W'(illegal_cond), W'(cs == 2'd3));
    chk({req, " R7/R8 next_ip"}, next_ip, exp_ip);
    chk({req, " R9 link_we"}, W'(link_we), W'(jt && li != 0));
    if (jt && li != 0) begin
      chk({req, " R9 link_data"}, link_data, ip);
      chk({req, " R9 link_idx"}, W'(link_idx_out), W'(li));
    end
    @(negedge clk);
    chk({req, " R11 idle"}, W'({out_valid, taken, move_en, link_we, illegal_cond}), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", W'(out_valid), 0);
    chk("R1 reset next_ip", next_ip, 0);
    chk("R11 reset flags", W'({taken, move_en, link_we, illegal_cond}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R2 zero test
    run("R2 zero hit", 0, 6'd5, 64'd0, 2'd0, 0, 64'h1000_0007, 64'h400, 6'd31);
    run("R2 zero miss", 0, 6'd5, 64'd8, 2'd0, 0, 64'h1000_0007, 64'h400, 6'd31);
    run("R2 r0 always", 0, 6'd0, 64'hDEAD, 2'd0, 0, 64'h2222_2223, 64'h800, 6'd1);
    // R3 MSB
    run("R3 msb hit", 0, 6'd9, 64'h8000_0000_0000_0000, 2'd1, 0, 64'h5555, 64'h10, 6'd2);
    run("R3 msb miss", 0, 6'd9, 64'h7FFF_FFFF_FFFF_FFFF, 2'd1, 0, 64'h5555, 64'h10, 6'd2);
    // R4 LSB
    run("R4 lsb hit", 0, 6'd3, 64'h1, 2'd2, 0, 64'hABC2, 64'h20, 6'd4);
    run("R4 lsb miss", 0, 6'd3, 64'h2, 2'd2, 0, 64'hABC2, 64'h20, 6'd4);
    // R5 negate
    run("R5 nonzero", 0, 6'd3, 64'h40, 2'd0, 1, 64'h3000, 64'h24, 6'd7);
    run("R5 msb clear", 0, 6'd3, 64'h1, 2'd1, 1, 64'h3001, 64'h28, 6'd7);
    run("R5 lsb clear", 0, 6'd3, 64'h1, 2'd2, 1, 64'h3001, 64'h28, 6'd7);
    // R6 reserved
    run("R6 rsvd", 0, 6'd0, 64'd0, 2'd3, 0, 64'h9000, 64'h30, 6'd1);
    run("R6 rsvd neg", 1, 6'd4, 64'd1, 2'd3, 1, 64'h9000, 64'h34, 6'd1);
    // R8 wrap
    run("R8 wrap", 0, 6'd4, 64'd1, 2'd0, 0, 64'h9000, 64'hFFFF_FFFF_FFFF_FFFE, 6'd1);
    // R9 link index 0
    run("R9 no link", 0, 6'd0, 64'd0, 2'd0, 0, 64'h7777, 64'h50, 6'd0);
    // R10 conditional move
    run("R10 move hit", 1, 6'd0, 64'd0, 2'd0, 0, 64'h7777, 64'h60, 6'd3);
    run("R10 move miss", 1, 6'd2, 64'd2, 2'd2, 0, 64'h7777, 64'h64, 6'd3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule